// File: doc/BRIEF.md
# Register-Fed Packet Stream Transmitter

The block takes 32-bit words from a single-cycle register-write port and holds them in an internal word queue. It sends whole packets on a stream master port (valid, ready, data, last). A word written to the data register is only held at first. The packet becomes eligible for the stream only when the host writes that packet's byte count to the length register. The committed words then leave in order, and `last` marks the final word of each packet.

A vacancy register reports how many word slots the host may still fill. Writing a key value to the flush register discards all queued words. Four sticky status bits record events: transmit done, overrun, length mismatch and flush done. Status bits are cleared by writing ones to them. An enable register selects which status bits drive the single interrupt line. Reads have no side effects: read data is a combinational function of the address.

Top module: `mmio_stream_tx`

## Requirements
- R1: A write to byte offset 0x10 queues one word when the vacancy is non-zero. Offset 0x0C reads the vacancy, which is (DEPTH - 4) minus the number of words held, committed or not.
- R2: Words that have not been committed by a length write never appear on the stream: `m_tvalid` stays low while only uncommitted words are queued.
- R3: Committed words leave on the stream in write order. `m_tlast` is high on the last word of each committed packet and low on all others. While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold.
- R4: Status bit 27 (transmit done) is set in the cycle after the last word of a packet is accepted on the stream.
- R5: A data write made while the vacancy is 0 is dropped and sets status bit 28 (overrun).
- R6: A write to offset 0x14 commits all uncommitted words as one packet. If the written byte count is not exactly 4 times that word count, status bit 25 (mismatch) is set, and the packet is still sent with the words that were queued.
- R7: A write to offset 0x14 while no uncommitted word is queued changes nothing except setting status bit 25. The vacancy and the stream output stay as they were.
- R8: Writing 0xA5 to offset 0x08 discards every queued word, restores the vacancy to DEPTH - 4, drops `m_tvalid` and sets status bit 24 (flush done). Any other value written there has no effect.
- R9: Offset 0x00 reads the status register. Writing ones there clears those bits, and a bit set in the same cycle stays set. Offset 0x04 is the enable register; only bits 31 to 19 are stored, and the other bits read as 0.
- R10: `irq` equals the OR over bits 31 to 19 of (status AND enable). With IRQ_REG = 1 it takes the value from one cycle earlier.
- R11: After reset, status and enable read 0, the vacancy reads DEPTH - 4, and `m_tvalid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32 | Stream word |
| m_tlast | output | 1 | Final word of a packet |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a second length write that arrives while a committed packet is still stalled on the stream. The bench gets there by holding `m_tready` low across the whole sequence: it queues and commits a packet, then writes the length again. It then checks that the vacancy and packet boundary are unchanged, and that only the original words drain. The flush path is tested the same way: with a committed packet stalled and an uncommitted tail behind it, a wrong key and then the real key are written. Sweeps cover every packet length from 1 to the full capacity, with the sink both always ready and stalling every third cycle.

// File: rtl/mst_pkg.sv
package mst_pkg;
   // register byte offsets
   localparam int OFS_STAT  = 'h00;
   localparam int OFS_IEN   = 'h04;
   localparam int OFS_FLUSH = 'h08;
   localparam int OFS_VAC   = 'h0C;
   localparam int OFS_DATA  = 'h10;
   localparam int OFS_LEN   = 'h14;

   localparam logic [31:0] FLUSH_KEY = 32'h0000_00A5;

   // status bit positions
   localparam int B_OVR     = 28;
   localparam int B_TXDONE  = 27;
   localparam int B_MISM    = 25;
   localparam int B_FLDONE  = 24;

   // interrupt-capable window
   localparam int IRQ_LO = 19;
   localparam int IRQ_HI = 31;
   localparam int IRQ_NB = IRQ_HI - IRQ_LO + 1;
endpackage

// File: rtl/mst_word_queue.sv
module mst_word_queue #(
   parameter int DEPTH = 64,
   parameter int DW    = 32,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_en,
   input  logic [DW-1:0] push_data,
   input  logic          commit_en,
   input  logic          flush_en,
   input  logic          pop_en,
   output logic [DW-1:0] head_data,
   output logic          head_last,
   output logic          ready_any,
   output logic [CW-1:0] free_slots,
   output logic [CW-1:0] open_words
);
   localparam int CAP = DEPTH - 4;

   logic [DW-1:0]    mem_q [DEPTH];
   logic [DEPTH-1:0] eop_q;
   logic [PW-1:0]    wp_q, rp_q;
   logic [PW-1:0]    last_slot;
   logic [CW-1:0]    fill_q, open_q, rdy_q;

   assign last_slot = wp_q - 1'b1;

   always_ff @(posedge clk) begin
      if (push_en) mem_q[wp_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush_en) begin
         wp_q   <= '0;
         rp_q   <= '0;
         fill_q <= '0;
         open_q <= '0;
         rdy_q  <= '0;
         eop_q  <= '0;
      end else begin
         if (push_en) begin
            wp_q        <= wp_q + 1'b1;
            eop_q[wp_q] <= 1'b0;
         end
         if (commit_en) eop_q[last_slot] <= 1'b1;
         if (pop_en) rp_q <= rp_q + 1'b1;
         fill_q <= fill_q + CW'(push_en) - CW'(pop_en);
         open_q <= commit_en ? '0 : open_q + CW'(push_en);
         rdy_q  <= rdy_q + (commit_en ? open_q : '0) - CW'(pop_en);
      end
   end

   assign head_data  = mem_q[rp_q];
   assign head_last  = eop_q[rp_q];
   assign ready_any  = (rdy_q != '0);
   assign free_slots = CW'(CAP) - fill_q;
   assign open_words = open_q;
endmodule

// File: rtl/mst_irq_regs.sv
module mst_irq_regs #(
   parameter bit IRQ_REG = 1'b1,
   parameter int NB      = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] set_bits,
   input  logic          clr_en,
   input  logic [NB-1:0] clr_bits,
   input  logic          ien_wr,
   input  logic [NB-1:0] ien_data,
   output logic [NB-1:0] stat,
   output logic [NB-1:0] ien,
   output logic          irq
);
   logic [NB-1:0] stat_q, ien_q;
   logic          pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         ien_q  <= '0;
      end else begin
         stat_q <= (stat_q & ~(clr_en ? clr_bits : '0)) | set_bits;
         if (ien_wr) ien_q <= ien_data;
      end
   end

   assign pend = |(stat_q & ien_q);
   assign stat = stat_q;
   assign ien  = ien_q;

   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= pend;
         end
      end else begin : g_irq_comb
         always_comb irq = pend;
      end
   endgenerate
endmodule

// File: rtl/mmio_stream_tx.sv
module mmio_stream_tx
   import mst_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int ADDR_W  = 6,
   parameter bit IRQ_REG = 1'b1,
   localparam int CW     = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              m_tvalid,
   input  logic              m_tready,
   output logic [31:0]       m_tdata,
   output logic              m_tlast,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
   localparam logic [ADDR_W-1:0] A_FLUSH = ADDR_W'(OFS_FLUSH);
   localparam logic [ADDR_W-1:0] A_VAC   = ADDR_W'(OFS_VAC);
   localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(OFS_LEN);

   generate
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 8");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must be at least 6");
      end
   endgenerate

   logic              wr_data, wr_len, wr_flush, wr_stat, wr_ien;
   logic              push_en, commit_en, flush_en, pop_en;
   logic              head_last, ready_any;
   logic [31:0]       head_data;
   logic [CW-1:0]     free_w, open_w;
   logic [IRQ_NB-1:0] stat_w, ien_w, set_w;
   logic              ovr_ev, mism_ev, done_ev;

   assign wr_data  = bus_wr && (bus_addr == A_DATA);
   assign wr_len   = bus_wr && (bus_addr == A_LEN);
   assign wr_flush = bus_wr && (bus_addr == A_FLUSH);
   assign wr_stat  = bus_wr && (bus_addr == A_STAT);
   assign wr_ien   = bus_wr && (bus_addr == A_IEN);

   assign flush_en  = wr_flush && (bus_wdata == FLUSH_KEY);
   assign push_en   = wr_data && (free_w != '0);
   assign ovr_ev    = wr_data && (free_w == '0);
   assign commit_en = wr_len && (open_w != '0);
   assign mism_ev   = wr_len && ((open_w == '0) || (bus_wdata != (32'(open_w) << 2)));
   assign pop_en    = m_tvalid && m_tready && !flush_en;
   assign done_ev   = pop_en && head_last;

   always_comb begin
      set_w                     = '0;
      set_w[B_OVR - IRQ_LO]    = ovr_ev;
      set_w[B_TXDONE - IRQ_LO] = done_ev;
      set_w[B_MISM - IRQ_LO]   = mism_ev;
      set_w[B_FLDONE - IRQ_LO] = flush_en;
   end

   mst_word_queue #(.DEPTH(DEPTH), .DW(32)) u_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_en    (push_en),
      .push_data  (bus_wdata),
      .commit_en  (commit_en),
      .flush_en   (flush_en),
      .pop_en     (pop_en),
      .head_data  (head_data),
      .head_last  (head_last),
      .ready_any  (ready_any),
      .free_slots (free_w),
      .open_words (open_w)
   );

   mst_irq_regs #(.IRQ_REG(IRQ_REG), .NB(IRQ_NB)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (set_w),
      .clr_en   (wr_stat),
      .clr_bits (bus_wdata[IRQ_HI:IRQ_LO]),
      .ien_wr   (wr_ien),
      .ien_data (bus_wdata[IRQ_HI:IRQ_LO]),
      .stat     (stat_w),
      .ien      (ien_w),
      .irq      (irq)
   );

   assign m_tvalid = ready_any;
   assign m_tdata  = head_data;
   assign m_tlast  = head_last;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_STAT)     bus_rdata = {stat_w, {IRQ_LO{1'b0}}};
      else if (bus_addr == A_IEN) bus_rdata = {ien_w, {IRQ_LO{1'b0}}};
      else if (bus_addr == A_VAC) bus_rdata = 32'(free_w);
   end
endmodule

// File: rtl/mst_chk.sv
module mst_chk
   import mst_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int ADDR_W  = 6,
   parameter bit IRQ_REG = 1'b1,
   localparam int CW     = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              m_tvalid,
   input logic              m_tready,
   input logic [31:0]       m_tdata,
   input logic              m_tlast,
   input logic              irq,
   input logic [IRQ_NB-1:0] stat,
   input logic [IRQ_NB-1:0] ien,
   input logic [CW-1:0]     free
);
   localparam int CAP = DEPTH - 4;
   logic flush_wr, data_wr;
   assign flush_wr = bus_wr && (bus_addr == ADDR_W'(OFS_FLUSH)) && (bus_wdata == FLUSH_KEY);
   assign data_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));

   // R1
   vac_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) free <= CW'(CAP));

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && !m_tready && !flush_wr |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

   // R4
   done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && m_tready && m_tlast && !flush_wr |=> stat[B_TXDONE - IRQ_LO]);

   // R5
   overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr && (free == '0) |=> stat[B_OVR - IRQ_LO]);

   // R8
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_wr |=> (free == CW'(CAP)) && !m_tvalid && stat[B_FLDONE - IRQ_LO]);

   generate
      if (IRQ_REG) begin : g_irq_ff
         // R10
         irq_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq == $past(|(stat & ien)));
      end else begin : g_irq_comb
         // R10
         irq_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq == |(stat & ien));
      end
   endgenerate
endmodule

bind mmio_stream_tx mst_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .m_tvalid  (m_tvalid),
   .m_tready  (m_tready),
   .m_tdata   (m_tdata),
   .m_tlast   (m_tlast),
   .irq       (irq),
   .stat      (stat_w),
   .ien       (ien_w),
   .free      (free_w)
);

// File: tb/mmio_stream_tx_bench.sv
module mmio_stream_tx_bench;
   localparam int DEPTH = 16;
   localparam int CAP   = DEPTH - 4;
   localparam logic [5:0] A_STAT = 6'h00, A_IEN = 6'h04, A_FL = 6'h08,
                          A_VAC = 6'h0C, A_DAT = 6'h10, A_LEN = 6'h14;
   localparam logic [31:0] BIT_OVR = 32'h1000_0000, BIT_DONE = 32'h0800_0000,
                           BIT_MISM = 32'h0200_0000, BIT_FL = 32'h0100_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        m_tvalid, m_tlast, irq;
   logic        m_tready = 1'b0;
   logic [31:0] m_tdata;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2ns clk = ~clk;

   mmio_stream_tx #(.DEPTH(DEPTH), .ADDR_W(6), .IRQ_REG(1'b1)) u_mmio_stream_tx (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .m_tvalid(m_tvalid),
      .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      bus_addr = a;
      #1ps;
      d = bus_rdata;
   endtask

   task automatic drain(input int n, input logic [31:0] base, input int mode, input string tag);
      int k = 0;
      int guard = 0;
      while (k < n && guard < 400) begin
         m_tready = (mode == 0) ? 1'b1 : ((guard % 3) != 1);
         #1ps;
         if (m_tvalid && m_tready) begin
            chk(tag, m_tdata, base + 32'(k));
            chk(tag, 32'(m_tlast), 32'(k == n - 1));
            k++;
         end
         guard++;
         @(negedge clk);
      end
      m_tready = 1'b0;
      chk(tag, 32'(k), 32'(n));
      chk(tag, 32'(m_tvalid), 32'd0);
   endtask

   initial begin
      #(4ns * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      rd(A_STAT, v); chk("R11 status", v, 32'd0);
      rd(A_IEN, v);  chk("R11 enable", v, 32'd0);
      rd(A_VAC, v);  chk("R11 vacancy", v, CAP);
      chk("R11 tvalid", 32'(m_tvalid), 0);
      chk("R11 irq", 32'(irq), 0);

      // R1 R2 R3 R4 R9: sweep every packet length, two sink patterns
      for (int len = 1; len <= CAP; len++) begin
         for (int i = 0; i < len; i++) wr(A_DAT, 32'(len * 256 + i));
         rd(A_VAC, v); chk("R1 vacancy after fill", v, 32'(CAP - len));
         repeat (2) @(negedge clk);
         chk("R2 uncommitted held back", 32'(m_tvalid), 0);
         wr(A_LEN, 32'(len * 4));
         drain(len, 32'(len * 256), len % 2, "R3 packet order/last");
         rd(A_VAC, v); chk("R1 vacancy restored", v, CAP);
         rd(A_STAT, v); chk("R4 done bit", v, BIT_DONE);
         wr(A_STAT, BIT_DONE);
         rd(A_STAT, v); chk("R9 w1c clear", v, 0);
      end

      // R5 overrun
      for (int i = 0; i <= CAP; i++) wr(A_DAT, 32'h1000 + 32'(i));
      rd(A_VAC, v); chk("R5 vacancy zero", v, 0);
      rd(A_STAT, v); chk("R5 overrun bit", v, BIT_OVR);
      wr(A_LEN, 32'(CAP * 4));
      drain(CAP, 32'h1000, 0, "R5 dropped word absent");
      rd(A_STAT, v); chk("R5 status after send", v, BIT_OVR | BIT_DONE);

      // R9 partial clear
      wr(A_STAT, BIT_OVR);
      rd(A_STAT, v); chk("R9 partial w1c", v, BIT_DONE);
      wr(A_STAT, 32'hFFFF_FFFF);

      // R6 mismatch: 3 words, 16 bytes; then 2 words, 7 bytes
      for (int i = 0; i < 3; i++) wr(A_DAT, 32'h2000 + 32'(i));
      wr(A_LEN, 32'd16);
      rd(A_STAT, v); chk("R6 mismatch bit", v, BIT_MISM);
      drain(3, 32'h2000, 1, "R6 short packet sent");
      wr(A_STAT, 32'hFFFF_FFFF);
      for (int i = 0; i < 2; i++) wr(A_DAT, 32'h2100 + 32'(i));
      wr(A_LEN, 32'd7);
      rd(A_STAT, v); chk("R6 unaligned length", v, BIT_MISM);
      drain(2, 32'h2100, 0, "R6 unaligned packet");
      wr(A_STAT, 32'hFFFF_FFFF);

      // R7 empty length write, alone and behind a stalled packet
      wr(A_LEN, 32'd8);
      rd(A_STAT, v); chk("R7 mismatch only", v, BIT_MISM);
      rd(A_VAC, v);  chk("R7 vacancy unchanged", v, CAP);
      repeat (2) @(negedge clk);
      chk("R7 no stream", 32'(m_tvalid), 0);
      wr(A_STAT, 32'hFFFF_FFFF);
      for (int i = 0; i < 2; i++) wr(A_DAT, 32'h3000 + 32'(i));
      wr(A_LEN, 32'd8);
      wr(A_LEN, 32'd8);
      rd(A_VAC, v);  chk("R7 vacancy with stalled packet", v, 32'(CAP - 2));
      rd(A_STAT, v); chk("R7 second write flagged", v, BIT_MISM);
      drain(2, 32'h3000, 0, "R7 boundary kept");
      wr(A_STAT, 32'hFFFF_FFFF);

      // R8 flush with committed and uncommitted words
      for (int i = 0; i < 4; i++) wr(A_DAT, 32'h4000 + 32'(i));
      wr(A_LEN, 32'd16);
      for (int i = 0; i < 3; i++) wr(A_DAT, 32'h4100 + 32'(i));
      wr(A_FL, 32'h0000_005A);
      rd(A_VAC, v);  chk("R8 wrong key ignored", v, 32'(CAP - 7));
      rd(A_STAT, v); chk("R8 wrong key no status", v, 0);
      chk("R8 wrong key stream kept", 32'(m_tvalid), 1);
      wr(A_FL, 32'h0000_00A5);
      rd(A_VAC, v);  chk("R8 vacancy after flush", v, CAP);
      rd(A_STAT, v); chk("R8 flush done bit", v, BIT_FL);
      chk("R8 stream dropped", 32'(m_tvalid), 0);
      wr(A_STAT, 32'hFFFF_FFFF);
      for (int i = 0; i < 2; i++) wr(A_DAT, 32'h5000 + 32'(i));
      wr(A_LEN, 32'd8);
      drain(2, 32'h5000, 1, "R8 queue usable after flush");

      // R9 R10 enable and interrupt
      rd(A_STAT, v); chk("R10 done pending", v, BIT_DONE);
      wr(A_IEN, BIT_MISM);
      repeat (2) @(negedge clk);
      chk("R10 masked irq low", 32'(irq), 0);
      wr(A_IEN, BIT_DONE);
      rd(A_IEN, v); chk("R9 enable readback", v, BIT_DONE);
      repeat (2) @(negedge clk);
      chk("R10 irq high", 32'(irq), 1);
      wr(A_IEN, 32'hFFFF_FFFF);
      rd(A_IEN, v); chk("R9 enable width", v, 32'hFFF8_0000);
      wr(A_STAT, BIT_DONE);
      repeat (2) @(negedge clk);
      chk("R10 irq after clear", 32'(irq), 0);
      wr(A_DAT, 32'h6000);
      wr(A_DAT, 32'h6001);
      wr(A_DAT, 32'h6002);
      wr(A_LEN, 32'd4);
      repeat (2) @(negedge clk);
      chk("R10 irq from mismatch", 32'(irq), 1);
      wr(A_STAT, 32'hFFFF_FFFF);
      repeat (2) @(negedge clk);
      chk("R10 irq cleared", 32'(irq), 0);
      drain(3, 32'h6000, 0, "R6 packet after irq test");

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule